// File: doc/BRIEF.md
# Hierarchy Recency Update Forwarder

This block keeps the recency state of a shared eight-way second-level cache aware of what a two-way first-level cache is doing. It watches every first-level access. It also decides whether that access should later refresh the recency stack of the matching second-level line. It holds a true-LRU age table for every second-level set. That table is refreshed from two sources. The first is demand updates, which come from first-level misses being looked up in the second level. The second is forwarded touches, which come from first-level hits.

A mode input selects the forwarding policy. With all-forwarding, every first-level hit becomes a touch. With MRU-only forwarding, a hit is forwarded only when the way it hit was already the most recently used way of its first-level set. Forwarded touches wait in a small FIFO and are applied only in cycles with no demand update. A touch that arrives when the FIFO is full is dropped and counted, so the first-level access is never held back. The victim way of any second-level set can be read through a registered query port.

Top module: `recency_fwd_top`

## Requirements
- R1: After reset, every way w of every second-level set has age w (age 0 is MRU, age 7 is LRU), so every set reports way 7 as victim. The FIFO is empty, drop_count is 0, and every first-level set has way 0 as MRU.
- R2: With mode_filt = 0, every access with acc_valid = 1 and acc_hit = 1 queues a touch for (acc_l2_set, acc_l2_way).
- R3: With mode_filt = 1, a hit queues a touch only when acc_l1_way equals the MRU way that its first-level set held before this access.
- R4: Every valid first-level access, hit or fill (acc_hit = 0), makes acc_l1_way the MRU way of acc_l1_set. A hit on the way that is already MRU leaves the state unchanged but is still forwarded when mode_filt = 1. Misses are never queued.
- R5: A demand update (dem_valid = 1) is applied at the next clock edge, ahead of any queued touch. After that edge, upd_valid = 1, upd_demand = 1, and upd_set/upd_way hold the demand address.
- R6: Queued touches are applied in arrival order, one per cycle, in cycles with dem_valid = 0. A touch queued at one edge is applied at the following edge at the earliest. An applied touch shows upd_valid = 1 with upd_demand = 0.
- R7: The FIFO holds 4 touches. A touch arriving while it already holds 4 is dropped, even if an entry leaves in that same cycle, and drop_count increments, saturating at 255. No input is ever stalled.
- R8: A touch whose acc_l2_present bit was 0 changes no age. When it leaves the FIFO it gives touch_err = 1 with upd_valid = 0 for one cycle.
- R9: An update of way w sets its age to 0 and adds 1 to the age of each way younger than w; older ways keep their age. q_victim shows, one edge after q_set is presented, the age-7 way of that set as it stood before any update made at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_filt | input | 1 | 0: forward all hits, 1: forward only MRU-way hits |
| acc_valid | input | 1 | A first-level access occurs this cycle |
| acc_hit | input | 1 | 1: hit on acc_l1_way, 0: fill into acc_l1_way |
| acc_l1_set | input | 4 | First-level set index |
| acc_l1_way | input | 1 | First-level way accessed |
| acc_l2_set | input | 4 | Second-level set of the accessed line |
| acc_l2_way | input | 3 | Second-level way holding the line |
| acc_l2_present | input | 1 | Line is present in the second level |
| dem_valid | input | 1 | Demand update from a first-level miss |
| dem_set | input | 4 | Demand second-level set |
| dem_way | input | 3 | Demand second-level way |
| q_set | input | 4 | Set whose victim is queried |
| q_victim | output | 3 | Registered LRU way of q_set |
| upd_valid | output | 1 | An age update was applied at the last edge |
| upd_demand | output | 1 | That update was a demand (1) or a touch (0) |
| upd_set | output | 4 | Set of the applied update |
| upd_way | output | 3 | Way of the applied update |
| touch_err | output | 1 | A touch to an absent line left the FIFO |
| drop_count | output | 8 | Saturating count of dropped touches |

## Verification
Each result has a fixed delay. A demand, an error pulse, a drop increment and a victim read all show up one edge after the cycle they are presented in. A forwarded hit shows up at least two edges after its access, and later if demands or older touches are ahead of it. The bench drives inputs on the falling edge and steps a behavioural model, built from queues and integer age tables, through exactly one clock edge. It then compares every output at the next falling edge. Because of this, each expected value is compared in the single cycle where it is due, never in a window.

// File: rtl/rfwd_pkg.sv
package rfwd_pkg;
  typedef enum logic {
    MODE_ALL      = 1'b0,
    MODE_MRU_ONLY = 1'b1
  } fwd_mode_e;
endpackage

// File: rtl/l1_mru_track.sv
module l1_mru_track #(
  parameter int SETS = 16,
  localparam int IW = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_set,
  input  logic          acc_way,
  output logic          mru_way
);
  // one bit per two-way set: the way touched most recently
  logic [SETS-1:0] mru_q;

  assign mru_way = mru_q[acc_set];

  always_ff @(posedge clk) begin
    if (rst) mru_q <= '0;
    else if (acc_valid) mru_q[acc_set] <= acc_way;
  end

  assert_mru_follows_R4: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> mru_q[$past(acc_set)] == $past(acc_way));
endmodule

// File: rtl/touch_fifo.sv
module touch_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign dout  = mem[rd_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wr_q <= nxt(wr_q);
      if (do_rd) rd_q <= nxt(rd_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  assert_full_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> full);
endmodule

// File: rtl/l2_age_lru.sv
module l2_age_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 8,
  localparam int SW = $clog2(SETS),
  localparam int AW = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en,
  input  logic [SW-1:0] upd_set,
  input  logic [AW-1:0] upd_way,
  input  logic [SW-1:0] q_set,
  output logic [AW-1:0] q_victim
);
  logic [AW-1:0] age_q   [SETS][WAYS];
  logic [AW-1:0] row_new [WAYS];
  logic [AW-1:0] cur_age;
  logic [WAYS-1:0] lru_hit;
  logic [AW-1:0] victim_c;

  assign cur_age = age_q[upd_set][upd_way];

  // touched way becomes age 0, only the ways younger than it grow older
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (AW'(w) == upd_way)            row_new[w] = '0;
      else if (age_q[upd_set][w] < cur_age) row_new[w] = age_q[upd_set][w] + 1'b1;
      else                              row_new[w] = age_q[upd_set][w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AW'(w);
    end else if (upd_en) begin
      for (int w = 0; w < WAYS; w++)
        age_q[upd_set][w] <= row_new[w];
    end
  end

  always_comb begin
    victim_c = '0;
    for (int w = 0; w < WAYS; w++) begin
      lru_hit[w] = (age_q[q_set][w] == AW'(WAYS - 1));
      if (lru_hit[w]) victim_c = AW'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q_victim <= AW'(WAYS - 1);
    else     q_victim <= victim_c;
  end

  assert_touch_to_mru_R9: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> age_q[$past(upd_set)][$past(upd_way)] == '0);
  assert_single_lru_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(lru_hit) == 1);
endmodule

// File: rtl/recency_fwd_top.sv
module recency_fwd_top #(
  parameter int L1_SETS = 16,
  parameter int L2_SETS = 16,
  parameter int L2_WAYS = 8,
  parameter int Q_DEPTH = 4,
  parameter int DROP_W  = 8,
  localparam int L1W = $clog2(L1_SETS),
  localparam int SW  = $clog2(L2_SETS),
  localparam int AW  = $clog2(L2_WAYS),
  localparam int EW  = 1 + SW + AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_filt,
  input  logic              acc_valid,
  input  logic              acc_hit,
  input  logic [L1W-1:0]    acc_l1_set,
  input  logic              acc_l1_way,
  input  logic [SW-1:0]     acc_l2_set,
  input  logic [AW-1:0]     acc_l2_way,
  input  logic              acc_l2_present,
  input  logic              dem_valid,
  input  logic [SW-1:0]     dem_set,
  input  logic [AW-1:0]     dem_way,
  input  logic [SW-1:0]     q_set,
  output logic [AW-1:0]     q_victim,
  output logic              upd_valid,
  output logic              upd_demand,
  output logic [SW-1:0]     upd_set,
  output logic [AW-1:0]     upd_way,
  output logic              touch_err,
  output logic [DROP_W-1:0] drop_count
);
  import rfwd_pkg::*;

  logic          l1_mru;
  logic          fwd_req;
  logic          q_empty, q_full, q_pop;
  logic [EW-1:0] q_din, q_head;
  logic          head_present;
  logic [SW-1:0] head_set;
  logic [AW-1:0] head_way;
  logic          lru_en;
  logic [SW-1:0] lru_set;
  logic [AW-1:0] lru_way;

  l1_mru_track #(.SETS(L1_SETS)) u_l1 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid),
    .acc_set(acc_l1_set), .acc_way(acc_l1_way), .mru_way(l1_mru)
  );

  // forwarding decision uses the MRU way seen before this access
  assign fwd_req = acc_valid && acc_hit &&
                   ((fwd_mode_e'(mode_filt) == MODE_ALL) || (acc_l1_way == l1_mru));
  assign q_din   = {acc_l2_present, acc_l2_set, acc_l2_way};
  assign q_pop   = !dem_valid && !q_empty;

  touch_fifo #(.DEPTH(Q_DEPTH), .W(EW)) u_q (
    .clk(clk), .rst(rst), .push(fwd_req), .din(q_din), .pop(q_pop),
    .dout(q_head), .empty(q_empty), .full(q_full)
  );

  assign {head_present, head_set, head_way} = q_head;

  // demand owns the single update port; a touch only fills idle cycles
  assign lru_en  = dem_valid || (q_pop && head_present);
  assign lru_set = dem_valid ? dem_set : head_set;
  assign lru_way = dem_valid ? dem_way : head_way;

  l2_age_lru #(.SETS(L2_SETS), .WAYS(L2_WAYS)) u_l2 (
    .clk(clk), .rst(rst), .upd_en(lru_en), .upd_set(lru_set),
    .upd_way(lru_way), .q_set(q_set), .q_victim(q_victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_valid  <= 1'b0;
      upd_demand <= 1'b0;
      upd_set    <= '0;
      upd_way    <= '0;
      touch_err  <= 1'b0;
      drop_count <= '0;
    end else begin
      upd_valid  <= lru_en;
      upd_demand <= dem_valid;
      upd_set    <= lru_set;
      upd_way    <= lru_way;
      touch_err  <= q_pop && !head_present;
      if (fwd_req && q_full && (drop_count != {DROP_W{1'b1}}))
        drop_count <= drop_count + 1'b1;
    end
  end

  assert_demand_first_R5: assert property (@(posedge clk) disable iff (rst)
    dem_valid |=> (upd_valid && upd_demand));
  assert_err_no_update_R8: assert property (@(posedge clk) disable iff (rst)
    touch_err |-> !upd_valid);
  assert_drop_monotonic_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> drop_count >= $past(drop_count));
  assert_miss_not_queued_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_hit && q_empty) |=> (q_empty || $past(dem_valid) == 1'b0));
endmodule

// File: tb/recency_fwd_top_bench.sv
`timescale 1ns/1ps
module recency_fwd_top_bench;
  localparam int DEPTH = 4;
  localparam int DMAX  = 255;

  logic clk = 1'b0;
  logic rst;
  logic mode_filt, acc_valid, acc_hit, acc_l1_way, acc_l2_present, dem_valid;
  logic [3:0] acc_l1_set, acc_l2_set, dem_set, q_set;
  logic [2:0] acc_l2_way, dem_way;
  logic [2:0] q_victim, upd_way;
  logic [3:0] upd_set;
  logic upd_valid, upd_demand, touch_err;
  logic [7:0] drop_count;

  always #2.5 clk = ~clk;

  recency_fwd_top u_recency_fwd_top (
    .clk(clk), .rst(rst), .mode_filt(mode_filt), .acc_valid(acc_valid),
    .acc_hit(acc_hit), .acc_l1_set(acc_l1_set), .acc_l1_way(acc_l1_way),
    .acc_l2_set(acc_l2_set), .acc_l2_way(acc_l2_way),
    .acc_l2_present(acc_l2_present), .dem_valid(dem_valid),
    .dem_set(dem_set), .dem_way(dem_way), .q_set(q_set),
    .q_victim(q_victim), .upd_valid(upd_valid), .upd_demand(upd_demand),
    .upd_set(upd_set), .upd_way(upd_way), .touch_err(touch_err),
    .drop_count(drop_count)
  );

  typedef struct { int s; int w; bit p; string tag; } ent_t;
  ent_t mq[$];
  int   ages [16][8];
  bit   m_mru [16];
  int   m_drop;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  int    e_uv, e_dem, e_set, e_way, e_err, e_vic;
  string e_tag;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int victim_of(int s);
    for (int w = 0; w < 8; w++) if (ages[s][w] == 7) return w;
    return -1;
  endfunction

  function automatic void touch(int s, int w);
    int a = ages[s][w];
    for (int v = 0; v < 8; v++) if (ages[s][v] < a) ages[s][v]++;
    ages[s][w] = 0;
  endfunction

  // one clock of the reference model, then compare after the edge
  task automatic tick();
    bit fwd = 0;
    int pre;
    ent_t e;
    e_vic = victim_of(int'(q_set));
    if (acc_valid) begin
      if (acc_hit && (mode_filt == 1'b0 || acc_l1_way == m_mru[acc_l1_set])) fwd = 1;
      m_mru[acc_l1_set] = acc_l1_way;
    end
    pre = mq.size();
    e_uv = 0; e_err = 0; e_dem = 0; e_set = 0; e_way = 0; e_tag = "R6";
    if (dem_valid) begin
      touch(int'(dem_set), int'(dem_way));
      e_uv = 1; e_dem = 1; e_set = int'(dem_set); e_way = int'(dem_way); e_tag = "R5";
    end else if (pre > 0) begin
      e = mq.pop_front();
      if (e.p) begin
        touch(e.s, e.w);
        e_uv = 1; e_set = e.s; e_way = e.w; e_tag = e.tag;
      end else begin
        e_err = 1; e_tag = "R8";
      end
    end
    if (fwd) begin
      if (pre == DEPTH) begin
        if (m_drop < DMAX) m_drop++;
      end else begin
        e.s = int'(acc_l2_set); e.w = int'(acc_l2_way); e.p = acc_l2_present;
        e.tag = mode_filt ? "R3/R4" : "R2";
        mq.push_back(e);
      end
    end
    @(negedge clk);
    chk(e_tag, "upd_valid", int'(upd_valid), e_uv);
    if (e_uv) begin
      chk(e_tag, "upd_demand", int'(upd_demand), e_dem);
      chk(e_tag, "upd_set", int'(upd_set), e_set);
      chk(e_tag, "upd_way", int'(upd_way), e_way);
    end
    chk("R8", "touch_err", int'(touch_err), e_err);
    chk("R7", "drop_count", int'(drop_count), m_drop);
    chk("R9", "q_victim", int'(q_victim), e_vic);
  endtask

  task automatic idle();
    acc_valid = 0; acc_hit = 0; acc_l1_set = 0; acc_l1_way = 0;
    acc_l2_set = 0; acc_l2_way = 0; acc_l2_present = 1;
    dem_valid = 0; dem_set = 0; dem_way = 0;
  endtask

  task automatic hit(int l1s, int l1w, int l2s, int l2w);
    idle();
    acc_valid = 1; acc_hit = 1; acc_l1_set = 4'(l1s); acc_l1_way = 1'(l1w);
    acc_l2_set = 4'(l2s); acc_l2_way = 3'(l2w);
  endtask

  task automatic rand_phase(int n, bit md, int pct_dem, int pct_absent);
    mode_filt = md;
    for (int i = 0; i < n; i++) begin
      acc_valid = ($urandom % 4) != 0;
      acc_hit = ($urandom % 4) != 0;
      acc_l1_set = 4'($urandom % 4);
      acc_l1_way = 1'($urandom % 2);
      acc_l2_set = 4'($urandom % 4);
      acc_l2_way = 3'($urandom % 8);
      acc_l2_present = ($urandom % 100) >= pct_absent;
      dem_valid = ($urandom % 100) < pct_dem;
      dem_set = 4'($urandom % 4);
      dem_way = 3'($urandom % 8);
      q_set = 4'($urandom % 4);
      tick();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      m_mru[s] = 0;
      for (int w = 0; w < 8; w++) ages[s][w] = w;
    end
    m_drop = 0;
    rst = 1; mode_filt = 0; q_set = 0; idle();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset values at the ports
    chk("R1", "upd_valid", int'(upd_valid), 0);
    chk("R1", "touch_err", int'(touch_err), 0);
    chk("R1", "drop_count", int'(drop_count), 0);
    chk("R1", "q_victim", int'(q_victim), 7);
    // R1: every set reports way 7 as victim
    for (int s = 0; s < 16; s++) begin
      q_set = 4'(s);
      tick();
    end
    // R3/R4: MRU-only forwarding on first-level set 2
    mode_filt = 1; q_set = 1;
    hit(2, 1, 1, 3); tick();   // way 1 not MRU: not forwarded
    hit(2, 1, 1, 4); tick();   // now MRU: forwarded
    hit(2, 1, 1, 5); tick();   // already MRU: still forwarded
    acc_valid = 1; acc_hit = 0; acc_l1_way = 0; tick(); // fill, never queued
    idle(); repeat (4) tick();
    // R2 and R3 under random traffic
    rand_phase(400, 0, 25, 0);
    rand_phase(400, 1, 25, 0);
    // R7: demands block the update port while hits pile up
    mode_filt = 0;
    for (int i = 0; i < 300; i++) begin
      hit(i % 4, i % 2, i % 4, i % 8);
      dem_valid = 1; dem_set = 4'(i % 4); dem_way = 3'((i + 3) % 8);
      q_set = 4'(i % 4);
      tick();
    end
    idle(); repeat (6) tick();
    // R8: touches to absent lines
    rand_phase(60, 0, 10, 100);
    rand_phase(300, 1, 30, 20);
    idle(); repeat (6) tick();
    finish_run();
  end
endmodule